// File: doc/BRIEF.md
# Stored-Address Active-Low Line Decoder

This block turns a binary address into one active-low select line. It can hold the address in a gated store. Each decode cell takes a three-bit select field. While the hold gate is low, the live field passes straight through to the decode. Once the gate is high, the cell decodes the address it saw at the last clock edge before the gate rose, and later changes on the select inputs have no effect until the gate drops again. Two enables of opposite polarity act on the outputs directly and do not pass through the store. With `en_hi_i` low or `en_lo_n_i` high, every line is high.

The top level cascades nine cells into a 6-to-64 decoder. A front cell decodes the upper address half. Its active-low lines drive the active-low enable of eight back cells, which all share the lower address half. All cells share one hold gate, so the full six-bit address is stored as a unit. The store is a clock-enabled register that loads while the gate is low. The decode path is combinational, so the outputs follow the inputs within the same cycle.

Top module: `lad_cascade_decoder`

## Requirements
- R1: `addr_i` is an unsigned address with bit 5 as its most significant bit. When enabled, output line index k (`line_n_o[k]`) is the line selected by effective address k.
- R2: While `hold_i` is low, the effective address is the live `addr_i`, and the outputs reflect it in the same cycle without waiting for a clock edge.
- R3: The store loads `addr_i` on every rising clock edge at which `hold_i` is low. While `hold_i` is high, the effective address is the stored value, and changes on `addr_i` leave all outputs unchanged.
- R4: Unless `en_hi_i` is 1 and `en_lo_n_i` is 0, all 64 outputs are 1.
- R5: When enabled, exactly one output is 0, at the index equal to the effective address. All others are 1.
- R6: The enables act on the outputs in the same cycle, whatever the state of `hold_i` and `addr_i`. A stored address is decoded as soon as the enables become active while `hold_i` stays high.
- R7: Driving `rst_n` low clears the store to address 0 at once. Release is synchronised over two clock edges. With `hold_i` high and the enables active during reset, line 0 is low.
- R8: Input assumption (setup): `addr_i` does not change across the clock edge at which `hold_i` is first sampled high.
- R9: Input assumption (pulse width): once `hold_i` rises, it stays high for at least `MIN_HOLD_HI` (default 2) rising clock edges.
- R10: In the cascade, address bits 5:3 select one of eight back cells through the front cell's active-low lines. Bits 2:0 select the line within that cell, giving line index = 8*bits[5:3] + bits[2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the address store |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hold_i | input | 1 | Hold gate: low = transparent, high = keep stored address |
| en_hi_i | input | 1 | Active-high output enable |
| en_lo_n_i | input | 1 | Active-low output enable |
| addr_i | input | 6 | Live address |
| line_n_o | output | 64 | Active-low decoded lines |

## Verification
The assertions assume the address is steady across the edge where the hold gate is first sampled high. They also assume the gate then stays high for a minimum number of edges. The hold-stability and setup checks depend on these, because the store samples on clock edges and not on the gate edge itself. The stimulus changes `addr_i` only on falling clock edges and raises the gate one full cycle after the address settles. It keeps the gate high for many edges, including across the mid-run reset pulse.

// File: rtl/lad_pkg.sv
package lad_pkg;
  localparam int unsigned DEF_SEL_W       = 3;
  localparam int unsigned DEF_MIN_HOLD_HI = 2;

  typedef struct packed {
    logic hi;
    logic lo_n;
  } en_pair_t;

  function automatic logic en_active(en_pair_t e);
    return e.hi & ~e.lo_n;
  endfunction
endpackage

// File: rtl/lad_rst_sync.sv
module lad_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/lad_addr_hold.sv
module lad_addr_hold #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] eff_o
);
  logic [W-1:0] q;
  logic [W-1:0] q_next;
  logic         load_en;

  assign load_en = ~hold_i;

  always_comb begin
    q_next = q;
    if (load_en) q_next = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

  assign eff_o = hold_i ? q : d_i;
endmodule

// File: rtl/lad_line_dec.sv
module lad_line_dec #(
  parameter int unsigned W = 3,
  localparam int unsigned N = 1 << W
) (
  input  logic         en_i,
  input  logic [W-1:0] idx_i,
  output logic [N-1:0] line_n_o
);
  for (genvar k = 0; k < N; k++) begin : g_line
    assign line_n_o[k] = ~(en_i && (idx_i == W'(k)));
  end
endmodule

// File: rtl/lad_cell.sv
module lad_cell
  import lad_pkg::*;
#(
  parameter int unsigned SEL_W       = DEF_SEL_W,
  parameter int unsigned MIN_HOLD_HI = DEF_MIN_HOLD_HI,
  localparam int unsigned N          = 1 << SEL_W,
  localparam int unsigned CW         = $clog2(MIN_HOLD_HI + 1) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  en_pair_t         en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [N-1:0]     line_n_o
);
  logic [SEL_W-1:0] eff_sel;
  logic             en;

  assign en = en_active(en_i);

  lad_addr_hold #(.W(SEL_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold_i (hold_i),
    .d_i    (sel_i),
    .eff_o  (eff_sel)
  );

  lad_line_dec #(.W(SEL_W)) u_dec (
    .en_i     (en),
    .idx_i    (eff_sel),
    .line_n_o (line_n_o)
  );

  // pulse-width counter used only by the R9 check
  logic [CW-1:0] hi_cnt_q;
  logic [CW-1:0] hi_cnt_d;

  always_comb begin
    hi_cnt_d = hi_cnt_q;
    if (!hold_i)                         hi_cnt_d = '0;
    else if (hi_cnt_q < CW'(MIN_HOLD_HI)) hi_cnt_d = hi_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt_q <= '0;
    else        hi_cnt_q <= hi_cnt_d;
  end

  a_r4_disabled_all_high: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_i.hi && !en_i.lo_n) |-> (&line_n_o));

  a_r5_single_low: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i.hi && !en_i.lo_n) |-> ($countones(~line_n_o) == 1));

  a_r3_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && $past(hold_i) && $stable(en_i)) |-> $stable(line_n_o));

  a_r8_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_i) |-> $stable(sel_i));

  a_r9_min_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_i) |-> (hi_cnt_q >= CW'(MIN_HOLD_HI)));
endmodule

// File: rtl/lad_cascade_decoder.sv
module lad_cascade_decoder
  import lad_pkg::*;
#(
  parameter int unsigned SEL_W       = DEF_SEL_W,
  parameter int unsigned MIN_HOLD_HI = DEF_MIN_HOLD_HI,
  localparam int unsigned ADDR_W     = 2 * SEL_W,
  localparam int unsigned CELL_N     = 1 << SEL_W,
  localparam int unsigned LINES      = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_i,
  input  logic              en_hi_i,
  input  logic              en_lo_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [LINES-1:0]  line_n_o
);
  logic            rst_q_n;
  logic            rst_cell_n;
  en_pair_t        front_en;
  logic [CELL_N-1:0] front_n;
  en_pair_t        back_en [CELL_N];

  lad_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  // store clears immediately on assertion, leaves reset in step with the clock
  assign rst_cell_n = rst_q_n & rst_n;

  assign front_en.hi   = en_hi_i;
  assign front_en.lo_n = en_lo_n_i;

  lad_cell #(.SEL_W(SEL_W), .MIN_HOLD_HI(MIN_HOLD_HI)) u_front (
    .clk      (clk),
    .rst_n    (rst_cell_n),
    .hold_i   (hold_i),
    .en_i     (front_en),
    .sel_i    (addr_i[ADDR_W-1:SEL_W]),
    .line_n_o (front_n)
  );

  for (genvar k = 0; k < CELL_N; k++) begin : g_back
    assign back_en[k].hi   = 1'b1;
    assign back_en[k].lo_n = front_n[k];

    lad_cell #(.SEL_W(SEL_W), .MIN_HOLD_HI(MIN_HOLD_HI)) u_back (
      .clk      (clk),
      .rst_n    (rst_cell_n),
      .hold_i   (hold_i),
      .en_i     (back_en[k]),
      .sel_i    (addr_i[SEL_W-1:0]),
      .line_n_o (line_n_o[k*CELL_N +: CELL_N])
    );
  end

  a_r10_one_line: assert property (@(posedge clk) disable iff (!rst_cell_n)
    (en_hi_i && !en_lo_n_i) |-> ($countones(~line_n_o) == 1));

  a_r4_top_idle: assert property (@(posedge clk) disable iff (!rst_cell_n)
    !(en_hi_i && !en_lo_n_i) |-> (&line_n_o));

  a_r2_live_index: assert property (@(posedge clk) disable iff (!rst_cell_n)
    (!hold_i && en_hi_i && !en_lo_n_i) |-> !line_n_o[addr_i]);
endmodule

// File: tb/lad_cascade_decoder_tb_top.sv
module lad_cascade_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hold;
  logic        en_hi;
  logic        en_lo_n;
  logic [5:0]  addr;
  logic [63:0] line_n;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  lad_cascade_decoder dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_i    (hold),
    .en_hi_i   (en_hi),
    .en_lo_n_i (en_lo_n),
    .addr_i    (addr),
    .line_n_o  (line_n)
  );

  function automatic logic [63:0] expect_lines(logic h, logic ln, int a);
    if (h && !ln) return ~(64'd1 << a);
    return {64{1'b1}};
  endfunction

  task automatic check(string req, logic [63:0] exp);
    vectors++;
    if (line_n !== exp) begin
      fails++;
      $display("FAIL %s: line_n_o=%h expected %h", req, line_n, exp);
    end
  endtask

  task automatic drive(logic g, logic h, logic ln, logic [5:0] a);
    @(negedge clk);
    hold = g; en_hi = h; en_lo_n = ln; addr = a;
    #1;
  endtask

  initial begin
    rst_n = 1'b0; hold = 1'b1; en_hi = 1'b1; en_lo_n = 1'b0; addr = 6'd37;
    #1;
    check("R7 reset store is address 0", expect_lines(1, 0, 0));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R7 held zero after release", expect_lines(1, 0, 0));

    // transparent sweep, all enable combinations (R1 R2 R4 R5 R10)
    for (int a = 0; a < 64; a++) begin
      for (int e = 0; e < 4; e++) begin
        drive(1'b0, e[1], e[0], 6'(a));
        check("R2/R4/R5/R10 transparent decode", expect_lines(e[1], e[0], a));
      end
    end
    drive(1'b0, 1'b1, 1'b0, 6'd11);
    check("R1 index 11 = bits 001_011", ~(64'd1 << 11));

    // capture and hold (R3 R6 R8 R9)
    for (int a = 0; a < 64; a++) begin
      drive(1'b0, 1'b1, 1'b0, 6'(a));
      drive(1'b1, 1'b1, 1'b0, 6'(a));
      check("R3 captured address", expect_lines(1, 0, a));
      for (int b = 0; b < 64; b += 7) begin
        drive(1'b1, 1'b1, 1'b0, 6'(b));
        check("R3 address change ignored while held", expect_lines(1, 0, a));
      end
      drive(1'b1, 1'b0, 1'b0, 6'(63 - a));
      check("R6 disabled while held", {64{1'b1}});
      drive(1'b1, 1'b1, 1'b1, 6'(a ^ 5));
      check("R6 low enable off while held", {64{1'b1}});
      drive(1'b1, 1'b1, 1'b0, 6'(a ^ 9));
      check("R6 stored address decoded on enable", expect_lines(1, 0, a));
      drive(1'b0, 1'b1, 1'b0, 6'(a ^ 9));
      check("R2 transparent again on gate low", expect_lines(1, 0, a ^ 9));
    end

    // asynchronous reset while held
    drive(1'b0, 1'b1, 1'b0, 6'd45);
    drive(1'b1, 1'b1, 1'b0, 6'd45);
    check("R3 captured 45", expect_lines(1, 0, 45));
    #1 rst_n = 1'b0;
    #1;
    check("R7 immediate clear to 0", expect_lines(1, 0, 0));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R7 store stays 0 after release", expect_lines(1, 0, 0));
    drive(1'b0, 1'b1, 1'b0, 6'd62);
    check("R10 line 62 via back cell 7", expect_lines(1, 0, 62));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule